// File: doc/BRIEF.md
# Carrier Detect Qualifier

This block turns a raw in-band activity indication, produced by an energy comparator after the receive bandpass filter, into a clean active-low carrier-detect output `cd_n`. Time is divided into fixed periods of `TICK_CLKS` system clocks, nominally 1 ms at the 3.579545 MHz reference. A period counts as active if the activity input was high in any cycle of it. Carrier is declared only when enough periods in a sliding window of recent periods were active. This keeps short bursts of in-band noise from asserting the output.

Once carrier is declared, it is held through short dropouts. It is withdrawn only after `HOLD_TICKS` consecutive quiet periods, nominally 8 ms. On withdrawal the window history is discarded, so a new declaration needs fresh evidence. The companion output `rx_en` tells the downstream deframer when it may use demodulated bits. While carrier is absent the deframer must ignore them. A power-down input returns the block to its idle state at once.

Top module: `cdq_top`

## Requirements
- R1: After reset, `cd_n` is 1 and `rx_en` is 0.
- R2: While carrier is absent, `cd_n` falls in the clock after a period end if at least `NEED_TICKS` of the last `WIN_TICKS` periods were active, counting the period just ending.
- R3: A period is active if `act_raw` is 1 in at least one of its `TICK_CLKS` cycles, in any position; a single-cycle strobe is enough.
- R4: While carrier is present, a run of fewer than `HOLD_TICKS` consecutive quiet periods does not raise `cd_n`, and a cycle with `act_raw` 1 never raises it in the next cycle.
- R5: While carrier is present, `cd_n` rises in the clock after the end of the `HOLD_TICKS`-th consecutive quiet period. At that point the window history is cleared, so re-declaration needs `NEED_TICKS` newly active periods.
- R6: `rx_en` is 1 exactly when `cd_n` is 0.
- R7: `pwr_down` high drives `cd_n` to 1 in the next cycle and clears the period timer, the window history and the quiet count. The first period after `pwr_down` falls starts with the first cycle in which it is low.
- R8: Other than by `pwr_down`, `cd_n` changes only in the clock after a period end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down | input | 1 | Synchronous power-down: forces idle and clears all counts |
| act_raw | input | 1 | Raw in-band activity from the energy comparator, sampled every clock |
| cd_n | output | 1 | Carrier detect, active low (0 = carrier present) |
| rx_en | output | 1 | Enable for the deframer, high while carrier is present |

## Verification
The properties assume that `act_raw` and `pwr_down` are synchronous to `clk`. They also assume the period timer starts from zero at reset and after every power-down. The bench relies on this by changing inputs only at the falling clock edge and by starting each stimulus pattern with a power-down pulse. The bound on the quiet interval while carrier is held assumes that activity, not power-down, ends each quiet run. The bench therefore asserts power-down only between patterns. The sweep drives every on/off pattern over ten periods. In each active period a single-cycle strobe moves through all positions, so the stimulus stays within the one-strobe-per-period case that the expected values are computed for.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

    typedef enum logic {
        CDQ_QUIET  = 1'b0,
        CDQ_LOCKED = 1'b1
    } cdq_state_e;

    typedef struct packed {
        cdq_state_e state;
    } cdq_top_s;

endpackage

// File: rtl/cdq_tick.sv
module cdq_tick #(
    parameter int TICK_CLKS = 3580
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int TW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_CLKS - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tick_s;

    tick_s r_d, r_q;

    always_comb begin
        r_d  = r_q;
        tick = (r_q.cnt == LAST);
        if (clr) begin
            r_d.cnt = '0;
            tick    = 1'b0;
        end else if (tick) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/cdq_window.sv
module cdq_window #(
    parameter int WIN_TICKS = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           flush,
    input  logic                           tick,
    input  logic                           act,
    output logic                           hit,
    output logic [$clog2(WIN_TICKS+1)-1:0] ones_next
);
    localparam int CW = $clog2(WIN_TICKS + 1);

    typedef struct packed {
        logic                 seen;
        logic [WIN_TICKS-1:0] hist;
    } win_s;

    win_s r_d, r_q;
    logic [WIN_TICKS-1:0] shifted;

    always_comb begin
        hit     = r_q.seen | act;
        shifted = {r_q.hist[WIN_TICKS-2:0], hit};
        ones_next = '0;
        for (int i = 0; i < WIN_TICKS; i++) begin
            ones_next = ones_next + CW'(shifted[i]);
        end
        r_d = r_q;
        if (clr) begin
            r_d = '0;
        end else if (tick) begin
            r_d.seen = 1'b0;
            r_d.hist = flush ? '0 : shifted;
        end else begin
            r_d.seen = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/cdq_hold.sv
module cdq_hold #(
    parameter int HOLD_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic hit,
    output logic expire
);
    localparam int QW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [QW-1:0] QLAST = QW'(HOLD_TICKS - 1);

    typedef struct packed {
        logic [QW-1:0] quiet;
    } hold_s;

    hold_s r_d, r_q;

    always_comb begin
        r_d    = r_q;
        expire = !clr && tick && !hit && (r_q.quiet == QLAST);
        if (clr) begin
            r_d.quiet = '0;
        end else if (tick) begin
            if (hit || expire) r_d.quiet = '0;
            else               r_d.quiet = r_q.quiet + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/cdq_top.sv
module cdq_top
    import cdq_pkg::*;
#(
    parameter int TICK_CLKS  = 3580,
    parameter int WIN_TICKS  = 10,
    parameter int NEED_TICKS = 8,
    parameter int HOLD_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic act_raw,
    output logic cd_n,
    output logic rx_en
);
    localparam int CW = $clog2(WIN_TICKS + 1);
    localparam logic [CW-1:0] NEED = CW'(NEED_TICKS);

    cdq_top_s  r_d, r_q;
    logic      tick_w;
    logic      hit_w;
    logic      expire_w;
    logic      flush_w;
    logic      hold_clr;
    logic [CW-1:0] ones_w;

    cdq_tick #(.TICK_CLKS(TICK_CLKS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pwr_down),
        .tick  (tick_w)
    );

    cdq_window #(.WIN_TICKS(WIN_TICKS)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pwr_down),
        .flush     (flush_w),
        .tick      (tick_w),
        .act       (act_raw),
        .hit       (hit_w),
        .ones_next (ones_w)
    );

    cdq_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (hold_clr),
        .tick   (tick_w),
        .hit    (hit_w),
        .expire (expire_w)
    );

    always_comb begin
        hold_clr = pwr_down || (r_q.state != CDQ_LOCKED);
        flush_w  = (r_q.state == CDQ_LOCKED) && expire_w;
        r_d      = r_q;
        if (pwr_down) begin
            r_d.state = CDQ_QUIET;
        end else begin
            unique case (r_q.state)
                CDQ_QUIET:  if (tick_w && (ones_w >= NEED)) r_d.state = CDQ_LOCKED;
                CDQ_LOCKED: if (expire_w)                   r_d.state = CDQ_QUIET;
                default:    r_d.state = CDQ_QUIET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: CDQ_QUIET};
        else        r_q <= r_d;
    end

    assign cd_n  = (r_q.state != CDQ_LOCKED);
    assign rx_en = (r_q.state == CDQ_LOCKED);
endmodule

// File: rtl/cdq_checker.sv
module cdq_checker #(
    parameter int TICK_CLKS  = 3580,
    parameter int WIN_TICKS  = 10,
    parameter int NEED_TICKS = 8,
    parameter int HOLD_TICKS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_down,
    input logic act_raw,
    input logic tick,
    input logic cd_n
);
    localparam int MIN_QUIET = HOLD_TICKS * TICK_CLKS;
    localparam int MAX_QUIET = (WIN_TICKS - NEED_TICKS + HOLD_TICKS + 1) * TICK_CLKS;

    int unsigned quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    quiet_q <= 0;
        else if (act_raw)              quiet_q <= 0;
        else if (quiet_q < 32'hFFFF_FFFF) quiet_q <= quiet_q + 1;
    end

    // R2: carrier declared only in the clock after a period end
    a_r2_fall_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cd_n) |-> $past(tick));

    // R8: release only after a period end or a power-down
    a_r8_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cd_n) |-> ($past(tick) || $past(pwr_down)));

    // R7: power-down forces carrier off next cycle
    a_r7_pd_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> cd_n);

    // R4: activity while locked keeps the lock
    a_r4_activity_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cd_n && act_raw && !pwr_down) |=> !cd_n);

    // R5: a normal release needs the full quiet interval
    a_r5_min_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cd_n) && !$past(pwr_down)) |-> (quiet_q >= MIN_QUIET));

    // R5: a quiet run cannot keep carrier asserted beyond its bound
    a_r5_max_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cd_n |-> (quiet_q <= MAX_QUIET));
endmodule

bind cdq_top cdq_checker #(
    .TICK_CLKS  (TICK_CLKS),
    .WIN_TICKS  (WIN_TICKS),
    .NEED_TICKS (NEED_TICKS),
    .HOLD_TICKS (HOLD_TICKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .act_raw  (act_raw),
    .tick     (tick_w),
    .cd_n     (cd_n)
);

// File: tb/sim_cdq_top.sv
module sim_cdq_top;
    localparam int TICK = 4;
    localparam int WIN  = 6;
    localparam int NEED = 3;
    localparam int HOLD = 2;
    localparam int NT   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_down = 1'b0;
    logic act_raw = 1'b0;
    logic cd_n;
    logic rx_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cdq_top #(
        .TICK_CLKS  (TICK),
        .WIN_TICKS  (WIN),
        .NEED_TICKS (NEED),
        .HOLD_TICKS (HOLD)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .act_raw  (act_raw),
        .cd_n     (cd_n),
        .rx_en    (rx_en)
    );

    task automatic check(input string tag, input logic exp_cd);
        n_cmp++;
        if (cd_n !== exp_cd) begin
            n_bad++;
            $display("FAIL %s cd_n actual=%b expected=%b t=%0t", tag, cd_n, exp_cd, $time);
        end
        n_cmp++;
        if (rx_en !== !exp_cd) begin
            n_bad++;
            $display("FAIL R6 rx_en actual=%b expected=%b t=%0t", rx_en, !exp_cd, $time);
        end
    endtask

    task automatic run_pattern(input int pat);
        bit         locked = 1'b0;
        bit         was;
        int         qc = 0;
        logic [WIN-1:0] wv = '0;
        logic [WIN-1:0] sh;
        string      tag;
        pwr_down = 1'b1;
        act_raw  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        pwr_down = 1'b0;
        check("R7", 1'b1);
        for (int k = 0; k < NT; k++) begin
            bit h = pat[k];
            int pos = (pat + k) % TICK;
            for (int c = 0; c < TICK; c++) begin
                act_raw = h && (c == pos);
                @(posedge clk);
                @(negedge clk);
                if (c != TICK - 1) begin
                    check("R8", !locked);
                end
            end
            was = locked;
            sh  = {wv[WIN-2:0], h};
            if (locked) begin
                if (!h && qc == HOLD - 1) begin
                    locked = 1'b0;
                    wv = '0;
                    qc = 0;
                end else begin
                    wv = sh;
                    qc = h ? 0 : qc + 1;
                end
            end else begin
                wv = sh;
                if ($countones(wv) >= NEED) locked = 1'b1;
            end
            if (locked && !was)      tag = "R2";
            else if (!locked && was) tag = "R5";
            else if (locked && !h)   tag = "R4";
            else                     tag = "R3";
            check(tag, !locked);
        end
        act_raw = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b1);
        for (int p = 0; p < (1 << NT); p++) begin
            run_pattern(p);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule